// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This engine drains a ring of transmit buffer descriptors held in system memory. Software prepares descriptors in a ring, writes the ring base, sets the enable input, and then pulses `kick`. The walker fetches the descriptor at its current pointer. If that descriptor is marked ready, the walker reads the buffer it points to and sends the bytes out on a byte-wide frame stream, one byte per cycle. It then returns the descriptor to software by writing it back with the ready flag cleared, and moves on to the next descriptor. The walk ends on the first descriptor that is not ready, or when a fixed descriptor budget for one kick has been used up.

The walker tracks frame boundaries. A descriptor carrying the last-in-frame flag closes the current frame: its final byte is tagged on the stream and a frame-done event pulses. Every consumed descriptor pulses a buffer-done event. A frame that would grow past the maximum frame size is clipped, and a babble event pulses. A wrap flag sends the pointer back to the ring base. Without it, the pointer steps forward by one descriptor. Memory is reached through a simple word-wide port: a request is held until it is acknowledged, and read data arrives together with the acknowledge.

Top module: `txring_walker`

## Requirements
- R1: After reset, `active`, `mem_req` and `fo_valid` are low, and the ring base and current pointer are zero.
- R2: A `kick` has effect only while `enable` is high and the walker is idle. A kick while `enable` is low issues no memory request and leaves `active` low.
- R3: A descriptor is two words at an 8-byte-aligned address P. The word at P holds the length in bits 15:0 and the flags in bits 31:16, with ready at bit 31, wrap at bit 29 and last at bit 27. The word at P+4 holds the buffer byte address.
- R4: A fetched descriptor whose ready bit is clear ends the walk. It is not written back, it raises no event, `active` falls, and the current pointer stays on that descriptor.
- R5: The bytes of a buffer leave on `fo_data` in ascending address order, with `fo_valid` high, one byte per cycle. Byte k of a 32-bit word is taken from bits 8k+7:8k. The buffer may start at any byte alignment, and each word touched is read once.
- R6: On a descriptor with the last flag, `fo_last` accompanies its final byte, `ev_frame_done` pulses, and the frame byte count starts again from zero. Each kick also starts that count at zero.
- R7: Each consumed descriptor produces exactly one `ev_buf_done` pulse.
- R8: After its bytes are sent, a descriptor's first word is written back to P with bit 31 cleared and all other bits unchanged. Only then does the walker move on.
- R9: After a consumed descriptor with the wrap flag, the next fetch is at the ring base. Otherwise it is at P+8. The next kick resumes at the saved pointer.
- R10: If a descriptor length exceeds the room left in the frame (MAX_FRAME minus the bytes already sent in that frame), only the remaining room is sent and `ev_babble` pulses.
- R11: At most MAX_DESC descriptors are consumed per kick. After that many, `active` falls and the pointer has advanced past the last one.
- R12: Lowering `enable` stops a walk at once: `active` falls, no further requests or bytes appear, and while `enable` is low the current pointer follows the ring base.
- R13: A ring base write discards address bits 2:0.
- R14: A memory request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; low aborts and parks the pointer on the base |
| base_wr | input | 1 | Ring base write strobe |
| base_wdata | input | ADDR_W | Ring base value (bits 2:0 ignored) |
| kick | input | 1 | Start a walk from the current pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| fo_valid | output | 1 | Frame byte valid |
| fo_data | output | 8 | Frame byte |
| fo_last | output | 1 | Final byte of a frame |
| ev_buf_done | output | 1 | Buffer-done pulse |
| ev_frame_done | output | 1 | Frame-done pulse |
| ev_babble | output | 1 | Frame clipped pulse |
| active | output | 1 | Walk in progress |

## Verification
The bench targets four corner cases.

The first is buffers that start and end mid-word. A design that miscounts lanes would send shifted or repeated bytes, or would read a word twice.

The second is the wrap flag paired with a descriptor that has already been handed back. A design that ignores wrap fetches P+8. A design that writes the whole word, or never writes it back, either loops or drops the ready handoff.

The third is a two-descriptor frame that crosses the size cap. Here the clip must land exactly on MAX_FRAME bytes and raise babble once.

The fourth is a read-only ring of ready, wrapping descriptors that would spin forever without the per-kick budget. Alongside these, an abort in the middle of a stream must leave the pointer on a freshly written base.

// File: rtl/txw_pkg.sv
package txw_pkg;

  // descriptor geometry: two 32-bit words per entry
  localparam int DESC_BYTES = 8;
  localparam int LEN_W      = 16;

  // flag positions inside the 16-bit flag half-word
  localparam int FLAG_READY = 15;
  localparam int FLAG_WRAP  = 13;
  localparam int FLAG_LAST  = 11;

  localparam logic [LEN_W-1:0] READY_MASK = LEN_W'(1) << FLAG_READY;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PTR,
    ST_WORD,
    ST_EMIT,
    ST_WB
  } txw_state_e;

  // bytes actually copied for a descriptor given the room left in the frame
  function automatic logic [LEN_W-1:0] clip_len(input logic [LEN_W-1:0] len,
                                                input logic [LEN_W-1:0] room);
    return (len > room) ? room : len;
  endfunction

  // descriptor address that follows the current one
  function automatic logic [31:0] next_desc(input logic [31:0] cur,
                                            input logic [31:0] base,
                                            input logic        wrap);
    return wrap ? base : (cur + 32'(DESC_BYTES));
  endfunction

endpackage

// File: rtl/txw_ring_ptr.sv
module txw_ring_ptr
  import txw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              step,
  input  logic              step_wrap,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] cur_q
);

  localparam int ALIGN_BITS = $clog2(DESC_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(DESC_BYTES - 1);

  logic [31:0] nxt_full;

  always_comb begin
    nxt_full = next_desc(32'(cur_q), 32'(base_q), step_wrap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_wr) begin
      base_q <= base_wdata & ALIGN_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (!enable) begin
      cur_q <= base_q;
    end else if (step) begin
      cur_q <= nxt_full[ADDR_W-1:0];
    end
  end

  // the low bits of both pointers never carry information
  logic unused_align;
  assign unused_align = ^{cur_q[ALIGN_BITS-1:0], base_q[ALIGN_BITS-1:0], nxt_full};

endmodule

// File: rtl/txw_budget.sv
module txw_budget
  import txw_pkg::*;
#(
  parameter int MAX_FRAME = 1518,
  parameter int MAX_DESC  = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             consume,
  input  logic             is_last,
  input  logic [LEN_W-1:0] copy_len,
  output logic [LEN_W-1:0] frame_room,
  output logic             limit_hit
);

  localparam int CNT_W = $clog2(MAX_DESC + 1);
  localparam logic [LEN_W-1:0] FRAME_CAP = LEN_W'(MAX_FRAME);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(MAX_DESC - 1);

  logic [LEN_W-1:0] used_q;
  logic [CNT_W-1:0] desc_cnt_q;

  assign frame_room = FRAME_CAP - used_q;
  assign limit_hit  = consume && (desc_cnt_q == LAST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q     <= '0;
      desc_cnt_q <= '0;
    end else if (start) begin
      used_q     <= '0;
      desc_cnt_q <= '0;
    end else if (consume) begin
      desc_cnt_q <= desc_cnt_q + 1'b1;
      used_q     <= is_last ? '0 : (used_q + copy_len);
    end
  end

endmodule

// File: rtl/txw_sequencer.sv
module txw_sequencer
  import txw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              kick,
  input  logic [ADDR_W-1:0] cur_ptr,
  input  logic [LEN_W-1:0]  frame_room,
  input  logic              limit_hit,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              fo_valid,
  output logic [7:0]        fo_data,
  output logic              fo_last,
  output logic              walk_start,
  output logic              desc_done,
  output logic              desc_wrap,
  output logic              desc_last,
  output logic [LEN_W-1:0]  desc_copy,
  output logic              ev_buf_done,
  output logic              ev_frame_done,
  output logic              ev_babble,
  output logic              active
);

  txw_state_e        state;
  logic [LEN_W-1:0]  flags_q;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] baddr_q;
  logic [LEN_W-1:0]  remain_q;
  logic [LEN_W-1:0]  copy_q;
  logic              over_q;
  logic [31:0]       word_q;
  logic              active_q;
  logic              ev_buf_q, ev_frame_q, ev_babble_q;
  logic [LEN_W-1:0]  copy_n;

  assign copy_n = clip_len(len_q, frame_room);

  // memory port driven straight from state
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_HDR:  begin mem_req = 1'b1; mem_addr = cur_ptr; end
      ST_PTR:  begin mem_req = 1'b1; mem_addr = cur_ptr + ADDR_W'(4); end
      ST_WORD: begin mem_req = 1'b1; mem_addr = {baddr_q[ADDR_W-1:2], 2'b00}; end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_ptr;
        mem_wdata = {flags_q & ~READY_MASK, len_q};
      end
      default: ;
    endcase
  end

  assign fo_valid = (state == ST_EMIT);
  assign fo_data  = word_q[{baddr_q[1:0], 3'b000} +: 8];
  assign fo_last  = fo_valid && (remain_q == LEN_W'(1)) && flags_q[FLAG_LAST];

  assign walk_start = (state == ST_IDLE) && kick && enable;
  assign desc_done  = (state == ST_WB) && mem_ack && enable;
  assign desc_wrap  = flags_q[FLAG_WRAP];
  assign desc_last  = flags_q[FLAG_LAST];
  assign desc_copy  = copy_q;

  assign ev_buf_done   = ev_buf_q;
  assign ev_frame_done = ev_frame_q;
  assign ev_babble     = ev_babble_q;
  assign active        = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      flags_q     <= '0;
      len_q       <= '0;
      baddr_q     <= '0;
      remain_q    <= '0;
      copy_q      <= '0;
      over_q      <= 1'b0;
      word_q      <= '0;
      active_q    <= 1'b0;
      ev_buf_q    <= 1'b0;
      ev_frame_q  <= 1'b0;
      ev_babble_q <= 1'b0;
    end else if (!enable) begin
      state       <= ST_IDLE;
      active_q    <= 1'b0;
      ev_buf_q    <= 1'b0;
      ev_frame_q  <= 1'b0;
      ev_babble_q <= 1'b0;
    end else begin
      ev_buf_q    <= desc_done;
      ev_frame_q  <= desc_done && flags_q[FLAG_LAST];
      ev_babble_q <= desc_done && over_q;
      unique case (state)
        ST_IDLE: begin
          if (kick) begin
            state    <= ST_HDR;
            active_q <= 1'b1;
          end
        end
        ST_HDR: begin
          if (mem_ack) begin
            flags_q <= mem_rdata[31:16];
            len_q   <= mem_rdata[15:0];
            if (mem_rdata[16 + FLAG_READY]) begin
              state <= ST_PTR;
            end else begin
              state    <= ST_IDLE;
              active_q <= 1'b0;
            end
          end
        end
        ST_PTR: begin
          if (mem_ack) begin
            baddr_q  <= mem_rdata[ADDR_W-1:0];
            remain_q <= copy_n;
            copy_q   <= copy_n;
            over_q   <= (len_q > frame_room);
            state    <= (copy_n == '0) ? ST_WB : ST_WORD;
          end
        end
        ST_WORD: begin
          if (mem_ack) begin
            word_q <= mem_rdata;
            state  <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          baddr_q  <= baddr_q + 1'b1;
          remain_q <= remain_q - 1'b1;
          if (remain_q == LEN_W'(1)) begin
            state <= ST_WB;
          end else if (baddr_q[1:0] == 2'b11) begin
            state <= ST_WORD;
          end
        end
        ST_WB: begin
          if (mem_ack) begin
            if (limit_hit) begin
              state    <= ST_IDLE;
              active_q <= 1'b0;
            end else begin
              state <= ST_HDR;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/txring_walker.sv
module txring_walker
  import txw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_FRAME = 1518,
  parameter int MAX_DESC  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              kick,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              fo_valid,
  output logic [7:0]        fo_data,
  output logic              fo_last,
  output logic              ev_buf_done,
  output logic              ev_frame_done,
  output logic              ev_babble,
  output logic              active
);

  // named internal events, visible to the bound checker
  logic              walk_start;
  logic              desc_done;
  logic              desc_wrap;
  logic              desc_last;
  logic [LEN_W-1:0]  desc_copy;
  logic [LEN_W-1:0]  frame_room;
  logic              limit_hit;
  logic [ADDR_W-1:0] ring_base;
  logic [ADDR_W-1:0] cur_ptr;

  txw_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .base_wr   (base_wr),
    .base_wdata(base_wdata),
    .step      (desc_done),
    .step_wrap (desc_wrap),
    .base_q    (ring_base),
    .cur_q     (cur_ptr)
  );

  txw_budget #(.MAX_FRAME(MAX_FRAME), .MAX_DESC(MAX_DESC)) u_budget (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (walk_start),
    .consume   (desc_done),
    .is_last   (desc_last),
    .copy_len  (desc_copy),
    .frame_room(frame_room),
    .limit_hit (limit_hit)
  );

  txw_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .kick         (kick),
    .cur_ptr      (cur_ptr),
    .frame_room   (frame_room),
    .limit_hit    (limit_hit),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata),
    .fo_valid     (fo_valid),
    .fo_data      (fo_data),
    .fo_last      (fo_last),
    .walk_start   (walk_start),
    .desc_done    (desc_done),
    .desc_wrap    (desc_wrap),
    .desc_last    (desc_last),
    .desc_copy    (desc_copy),
    .ev_buf_done  (ev_buf_done),
    .ev_frame_done(ev_frame_done),
    .ev_babble    (ev_babble),
    .active       (active)
  );

endmodule

// File: rtl/txw_checker.sv
module txw_checker #(
  parameter int ADDR_W    = 32,
  parameter int MAX_FRAME = 1518,
  parameter int MAX_DESC  = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              fo_valid,
  input logic              ev_buf_done,
  input logic              ev_frame_done,
  input logic              active,
  input logic              walk_start
);

  int desc_seen;
  int frame_bytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_seen   <= 0;
      frame_bytes <= 0;
    end else begin
      if (walk_start)       desc_seen <= 0;
      else if (ev_buf_done) desc_seen <= desc_seen + 1;
      if (walk_start || ev_frame_done) frame_bytes <= 0;
      else if (fo_valid)               frame_bytes <= frame_bytes + 1;
    end
  end

  // R14: pending request stays put until acknowledged
  a_r14_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && enable) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R8: write-back hands the descriptor back and targets an aligned entry
  a_r8_wb_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (!mem_wdata[31] && (mem_addr[2:0] == 3'b000)));

  // R6: a frame-done pulse always comes with its buffer-done pulse
  a_r6_frame_with_buf: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_done |-> ev_buf_done);

  // R12: dropping enable silences the walker on the next cycle
  a_r12_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!active && !mem_req && !fo_valid));

  // R5: bytes only flow during a walk
  a_r5_emit_active: assert property (@(posedge clk) disable iff (!rst_n)
    fo_valid |-> active);

  // R11: descriptor budget per kick
  a_r11_desc_budget: assert property (@(posedge clk) disable iff (!rst_n)
    desc_seen <= MAX_DESC);

  // R10: no frame longer than the cap
  a_r10_frame_cap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bytes <= MAX_FRAME);

endmodule

bind txring_walker txw_checker #(
  .ADDR_W(ADDR_W), .MAX_FRAME(MAX_FRAME), .MAX_DESC(MAX_DESC)
) u_txw_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_ack      (mem_ack),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .fo_valid     (fo_valid),
  .ev_buf_done  (ev_buf_done),
  .ev_frame_done(ev_frame_done),
  .active       (active),
  .walk_start   (walk_start)
);

// File: tb/txring_walker_bench.sv
module txring_walker_bench;

  localparam int MAXF   = 1518;
  localparam int MAXD   = 1024;
  localparam int ROM_LO = 32'hF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        base_wr = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        kick = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        fo_valid, fo_last;
  logic [7:0]  fo_data;
  logic        ev_buf_done, ev_frame_done, ev_babble, active;

  always #5 clk = ~clk;

  txring_walker u_txring_walker (
    .clk(clk), .rst_n(rst_n), .enable(enable), .base_wr(base_wr),
    .base_wdata(base_wdata), .kick(kick), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .fo_valid(fo_valid), .fo_data(fo_data),
    .fo_last(fo_last), .ev_buf_done(ev_buf_done), .ev_frame_done(ev_frame_done),
    .ev_babble(ev_babble), .active(active)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory and reference model ----------------
  logic [31:0] mem [0:1023];

  typedef struct { logic we; logic [31:0] addr; logic [31:0] wdata; } acc_t;
  acc_t        acc_q[$];
  string       tag_q[$];
  logic [8:0]  byte_q[$];
  int exp_txb, exp_txf, exp_babt;
  int got_txb, got_txf, got_babt;
  logic [31:0] m_base = '0;
  logic [31:0] m_ptr  = '0;
  logic [31:0] first_addr;
  bit          first_seen;

  function automatic void push_acc(logic we, logic [31:0] a, logic [31:0] d, string t);
    acc_t e;
    e.we = we; e.addr = a; e.wdata = d;
    acc_q.push_back(e);
    tag_q.push_back(t);
  endfunction

  task automatic model_walk();
    logic [31:0] sh [0:1023];
    logic [31:0] ptr, w0, ba, a, wd;
    int used, n, len, room, cp;
    for (int i = 0; i < 1024; i++) sh[i] = mem[i];
    ptr = m_ptr; used = 0; n = 0;
    exp_txb = 0; exp_txf = 0; exp_babt = 0;
    forever begin
      push_acc(1'b0, ptr, 32'h0, "R9");
      w0 = sh[ptr[11:2]];
      if (!w0[31]) break;
      push_acc(1'b0, ptr + 4, 32'h0, "R3");
      ba  = sh[(ptr + 4) >> 2];
      len = int'(w0[15:0]);
      room = MAXF - used;
      cp = (len > room) ? room : len;
      if (len > room) exp_babt++;
      for (int i = 0; i < cp; i++) begin
        a = ba + i;
        if (i == 0 || a[1:0] == 2'b00) push_acc(1'b0, {a[31:2], 2'b00}, 32'h0, "R5");
        byte_q.push_back({(i == cp - 1) && w0[27], sh[a[11:2]][8*a[1:0] +: 8]});
      end
      wd = w0 & 32'h7FFF_FFFF;
      push_acc(1'b1, ptr, wd, "R8");
      if (ptr < ROM_LO) sh[ptr[11:2]] = wd;
      exp_txb++;
      if (w0[27]) begin exp_txf++; used = 0; end else used += cp;
      ptr = w0[29] ? m_base : ptr + 8;
      n++;
      if (n == MAXD) break;
    end
    m_ptr = ptr;
  endtask

  // memory responder: every other access stalls one cycle
  bit          stall_tog = 1'b0;
  bit          waited = 1'b0;
  logic [31:0] held_addr;
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (rst_n && mem_req) begin
      if (!waited && stall_tog) begin
        waited = 1'b1;
        held_addr = mem_addr;
      end else begin
        if (waited) chk(mem_addr == held_addr, "R14", "request held", mem_addr, held_addr);
        waited = 1'b0;
        stall_tog = ~stall_tog;
        if (!first_seen) begin first_seen = 1'b1; first_addr = mem_addr; end
        if (acc_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected access", mem_addr, 0);
        end else begin
          acc_t e;
          string t;
          e = acc_q.pop_front();
          t = tag_q.pop_front();
          chk(mem_we == e.we && mem_addr == e.addr && (!e.we || mem_wdata == e.wdata),
              t, "access", {mem_we, mem_addr}, {e.we, e.addr});
          if (e.we) chk(mem_wdata == e.wdata, t, "write data", mem_wdata, e.wdata);
        end
        if (mem_we) begin
          if (mem_addr < ROM_LO) mem[mem_addr[11:2]] = mem_wdata;
        end else begin
          mem_rdata = mem[mem_addr[11:2]];
        end
        mem_ack = 1'b1;
      end
    end else begin
      waited = 1'b0;
    end
  end

  // stream and event monitor, compared every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (fo_valid) begin
        if (byte_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected byte", fo_data, 0);
        end else begin
          logic [8:0] eb;
          eb = byte_q.pop_front();
          chk(fo_data == eb[7:0], "R5", "byte", fo_data, eb[7:0]);
          chk(fo_last == eb[8], "R6", "last tag", fo_last, eb[8]);
        end
      end
      if (ev_buf_done) got_txb++;
      if (ev_frame_done) got_txf++;
      if (ev_babble) got_babt++;
    end
  end

  // watchdog
  int  cyc = 0;
  bit  done = 1'b0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected<190000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic walk(input string name);
    int guard;
    if (enable) model_walk();
    got_txb = 0; got_txf = 0; got_babt = 0;
    first_seen = 1'b0;
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
    guard = 0;
    while (active && guard < 40000) begin @(negedge clk); guard++; end
    @(negedge clk);
    chk(acc_q.size() == 0, "R4", {name, " accesses left"}, acc_q.size(), 0);
    chk(byte_q.size() == 0, "R5", {name, " bytes left"}, byte_q.size(), 0);
    chk(got_txb == exp_txb, "R7", {name, " buffer events"}, got_txb, exp_txb);
    chk(got_txf == exp_txf, "R6", {name, " frame events"}, got_txf, exp_txf);
    chk(got_babt == exp_babt, "R10", {name, " babble events"}, got_babt, exp_babt);
    acc_q.delete(); tag_q.delete(); byte_q.delete();
  endtask

  task automatic set_base(input logic [31:0] v);
    @(negedge clk) begin base_wr = 1'b1; base_wdata = v; end
    @(negedge clk) base_wr = 1'b0;
    m_base = v & 32'hFFFF_FFF8;
    if (!enable) m_ptr = m_base;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = (i * 32'h9E37_79B1) ^ 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(active == 1'b0, "R1", "active after reset", active, 0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
    chk(fo_valid == 1'b0, "R1", "fo_valid after reset", fo_valid, 0);

    // R2 kick while disabled is ignored
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
    repeat (20) @(negedge clk);
    chk(active == 1'b0, "R2", "active after disabled kick", active, 0);

    // R13 misaligned base
    set_base(32'h105);
    enable = 1'b1;
    @(negedge clk);
    mem[32'h100 >> 2] = 32'h8000_0005; mem[32'h104 >> 2] = 32'h403;
    mem[32'h108 >> 2] = 32'h8800_0006; mem[32'h10C >> 2] = 32'h421;
    mem[32'h110 >> 2] = 32'h0000_0000;
    walk("two-desc frame");
    chk(first_addr == 32'h100, "R13", "first fetch at aligned base", first_addr, 32'h100);
    chk(mem[32'h110 >> 2] == 32'h0, "R4", "not-ready desc untouched", mem[32'h110 >> 2], 0);
    chk(mem[32'h100 >> 2] == 32'h0000_0005, "R8", "desc0 handed back", mem[32'h100 >> 2], 32'h5);

    // R9 resume from saved pointer, then wrap back to base
    mem[32'h110 >> 2] = 32'hA800_0004; mem[32'h114 >> 2] = 32'h43E;
    walk("resume and wrap");
    chk(first_addr == 32'h110, "R9", "resume at saved pointer", first_addr, 32'h110);

    // R10 frame clipped across two descriptors
    mem[32'h100 >> 2] = 32'h8000_03E8; mem[32'h104 >> 2] = 32'h800;
    mem[32'h108 >> 2] = 32'h8800_03E8; mem[32'h10C >> 2] = 32'h800;
    walk("clipped frame");

    // R12 abort mid-stream, rebase while disabled
    mem[32'h110 >> 2] = 32'h8800_0028; mem[32'h114 >> 2] = 32'h500;
    model_walk();
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
    repeat (12) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(active == 1'b0, "R12", "active after disable", active, 0);
    chk(fo_valid == 1'b0, "R12", "stream quiet after disable", fo_valid, 0);
    acc_q.delete(); tag_q.delete(); byte_q.delete();
    set_base(32'h300);
    mem[32'h300 >> 2] = 32'hA800_0003; mem[32'h304 >> 2] = 32'h601;
    enable = 1'b1;
    @(negedge clk);
    walk("after rebase");
    chk(first_addr == 32'h300, "R12", "pointer follows base", first_addr, 32'h300);

    // R11 read-only ring of ready wrapping descriptors
    enable = 1'b0;
    @(negedge clk);
    set_base(32'hF00);
    mem[32'hF00 >> 2] = 32'hA800_0000; mem[32'hF04 >> 2] = 32'h0;
    enable = 1'b1;
    @(negedge clk);
    walk("budget");
    chk(got_txb == MAXD, "R11", "descriptors per kick", got_txb, MAXD);
    chk(active == 1'b0, "R11", "walk stopped", active, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule